// File: doc/BRIEF.md
# Three-Level Vectored Interrupt Arbiter

The block collects interrupt requests on ten vector lines and gives each vector one of two priority levels chosen by a per-vector select bit. There are three levels in total: highest, high and low. The first two vectors can sit at highest or low, and the other eight can sit at high or low. Among the requests that are allowed through, the arbiter picks one winner. The winner is the one at the highest level, and on a tie at that level it is the lowest vector index. The arbiter raises a request to the CPU for it. When the CPU acknowledges, the arbiter latches the winner's vector address and marks the winner's level as in service.

A three-bit in-service record holds one bit per level. It makes nesting behave correctly. A request reaches the CPU only when its level is strictly above the highest level now in service, so equal or lower levels wait. A return-from-interrupt strobe retires the highest active level. Vector addresses start at 0x0003 and are spaced eight bytes apart. The reset input is asynchronous and active low. Its release is synchronized inside the block, so the block leaves reset two clock edges after the reset input rises.

Top module: `intc_arbiter`

## Requirements
- R1: After reset release, irq_o is 0, vec_addr_o is 0x0000 and svc_level_o is 0.
- R2: The level of vector index i (0..9) is 1 (low) when lvl_sel_i[i] is 0. When lvl_sel_i[i] is 1, the level is 3 (highest) for i in 0..1 and 2 (high) for i in 2..9.
- R3: irq_o is 1 exactly when gie_i is 1 and at least one req_i bit belongs to a vector whose level is strictly greater than svc_level_o. It follows the inputs in the same cycle.
- R4: Among eligible requests, the winner has the greatest level. Among winners of equal level, the lowest index wins.
- R5: The vector address for index i is 0x0003 + 8*i, covering 0x0003 to 0x004B.
- R6: An ack_i sampled high while irq_o is 1 and ret_i is 0 loads the winner's address into vec_addr_o. It also marks the winner's level in service, so svc_level_o equals that level from the next cycle.
- R7: vec_addr_o changes only on an accepted acknowledge. An ack_i while irq_o is 0 (including when gie_i is 0) changes neither output.
- R8: While a level is in service, requests at that level or below leave irq_o at 0, even though requests at higher levels still reach the CPU.
- R9: ret_i clears the highest in-service level. svc_level_o then shows the next lower active level, or 0 when none is left.
- R10: When ack_i and ret_i are both high in one cycle, only the return takes effect, and vec_addr_o is unchanged.
- R11: ret_i with nothing in service leaves svc_level_o at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 10 | Request line per vector, bit i = vector index i |
| lvl_sel_i | input | 10 | Per-vector level select: 0 selects low, 1 selects the upper level of that vector |
| gie_i | input | 1 | Master interrupt enable |
| ack_i | input | 1 | CPU acknowledge strobe |
| ret_i | input | 1 | Return-from-interrupt strobe |
| irq_o | output | 1 | Interrupt request to the CPU |
| vec_addr_o | output | 16 | Vector address latched on acknowledge |
| svc_level_o | output | 2 | Highest level in service: 0 none, 1 low, 2 high, 3 highest |

## Verification
A corrupted in-service record shows up at the ports within one cycle. svc_level_o reports the wrong level, and the next request at a neighbouring level is either passed when it should be blocked or blocked when it should pass. A wrong winner or a wrong address shows in vec_addr_o on the cycle right after the acknowledge. A lost or doubled return shows up as a level that stays in service, or one that is retired too early, when the return sequence unwinds. The sweeps cover every request pattern against several select patterns, both with an empty record and with low already in service. They are followed by directed nesting, same-cycle acknowledge and return, and empty-return cases.

// File: rtl/intc_pkg.sv
package intc_pkg;
  typedef logic [1:0] lvl_t;
  localparam lvl_t LVL_NONE = 2'd0;
  localparam lvl_t LVL_LOW  = 2'd1;
  localparam lvl_t LVL_HIGH = 2'd2;
  localparam lvl_t LVL_TOP  = 2'd3;
endpackage

// File: rtl/intc_level_map.sv
module intc_level_map
  import intc_pkg::*;
#(
  parameter int NVEC = 10,
  parameter int NTOP = 2
) (
  input  logic [NVEC-1:0]      sel_i,
  output logic [NVEC-1:0][1:0] lvl_o
);
  genvar g;
  generate
    for (g = 0; g < NVEC; g++) begin : g_vec
      if (g < NTOP) begin : g_top
        assign lvl_o[g] = sel_i[g] ? LVL_TOP : LVL_LOW;
      end else begin : g_high
        assign lvl_o[g] = sel_i[g] ? LVL_HIGH : LVL_LOW;
      end
    end
  endgenerate
endmodule

// File: rtl/intc_priority_pick.sv
module intc_priority_pick
  import intc_pkg::*;
#(
  parameter int NVEC  = 10,
  localparam int IDX_W = $clog2(NVEC)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NVEC-1:0]      req_i,
  input  logic [NVEC-1:0][1:0] lvl_i,
  input  lvl_t                 floor_i,
  input  logic                 en_i,
  output logic                 valid_o,
  output logic [IDX_W-1:0]     idx_o,
  output lvl_t                 lvl_o
);
  logic [IDX_W-1:0] best_idx;
  lvl_t             best_lvl;
  logic             found;

  always_comb begin
    best_idx = '0;
    best_lvl = LVL_NONE;
    found    = 1'b0;
    for (int i = NVEC - 1; i >= 0; i--) begin
      if (req_i[i] && (lvl_i[i] > floor_i) && (lvl_i[i] >= best_lvl)) begin
        best_idx = IDX_W'(i);
        best_lvl = lvl_i[i];
        found    = 1'b1;
      end
    end
  end

  assign valid_o = en_i & found;
  assign idx_o   = best_idx;
  assign lvl_o   = best_lvl;

  // R3
  no_low_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> (lvl_o > floor_i));
  // R3
  no_masked_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |-> !valid_o);
  // R4
  win_is_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> req_i[idx_o]);
endmodule

// File: rtl/intc_service_stack.sv
module intc_service_stack
  import intc_pkg::*;
#(
  parameter int NLVL = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic push_i,
  input  lvl_t push_lvl_i,
  input  logic pop_i,
  output lvl_t top_o
);
  logic [NLVL-1:0] act_q, act_d;

  always_comb begin
    top_o = LVL_NONE;
    for (int k = 0; k < NLVL; k++) begin
      if (act_q[k]) top_o = lvl_t'(k + 1);
    end
  end

  always_comb begin
    act_d = act_q;
    if (pop_i) begin
      if (top_o != LVL_NONE) act_d[top_o - 2'd1] = 1'b0;
    end else if (push_i && push_lvl_i != LVL_NONE) begin
      act_d[push_lvl_i - 2'd1] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_q <= '0;
    else        act_q <= act_d;
  end

  // R9
  pop_lowers_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && top_o != LVL_NONE) |=> (top_o < $past(top_o)));
  // R11
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && top_o == LVL_NONE) |=> (top_o == LVL_NONE));
  // R6
  push_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && !pop_i && push_lvl_i > top_o) |=> (top_o == $past(push_lvl_i)));
  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!push_i && !pop_i) |=> $stable(top_o));
endmodule

// File: rtl/intc_arbiter.sv
module intc_arbiter
  import intc_pkg::*;
#(
  parameter int NVEC   = 10,
  parameter int NTOP   = 2,
  parameter int ADDR_W = 16,
  parameter int BASE   = 3,
  parameter int STRIDE = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NVEC-1:0]   req_i,
  input  logic [NVEC-1:0]   lvl_sel_i,
  input  logic              gie_i,
  input  logic              ack_i,
  input  logic              ret_i,
  output logic              irq_o,
  output logic [ADDR_W-1:0] vec_addr_o,
  output logic [1:0]        svc_level_o
);
  localparam int IDX_W = $clog2(NVEC);

  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [NVEC-1:0][1:0] vec_lvl;
  logic                 win_valid;
  logic [IDX_W-1:0]     win_idx;
  lvl_t                 win_lvl;
  lvl_t                 svc_top;
  logic                 accept;
  logic [ADDR_W-1:0]    addr_q, addr_d;

  intc_level_map #(.NVEC(NVEC), .NTOP(NTOP)) u_map (
    .sel_i (lvl_sel_i),
    .lvl_o (vec_lvl)
  );

  intc_priority_pick #(.NVEC(NVEC)) u_pick (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .req_i   (req_i),
    .lvl_i   (vec_lvl),
    .floor_i (svc_top),
    .en_i    (gie_i),
    .valid_o (win_valid),
    .idx_o   (win_idx),
    .lvl_o   (win_lvl)
  );

  assign accept = ack_i & win_valid & ~ret_i;

  intc_service_stack #(.NLVL(3)) u_stack (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .push_i     (accept),
    .push_lvl_i (win_lvl),
    .pop_i      (ret_i),
    .top_o      (svc_top)
  );

  always_comb begin
    addr_d = addr_q;
    if (accept) addr_d = ADDR_W'(BASE) + ADDR_W'(STRIDE) * ADDR_W'(win_idx);
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) addr_q <= '0;
    else            addr_q <= addr_d;
  end

  assign irq_o       = win_valid;
  assign vec_addr_o  = addr_q;
  assign svc_level_o = svc_top;

  // R7
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    !accept |=> $stable(vec_addr_o));
  // R10
  ret_wins_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (ack_i && ret_i) |=> $stable(vec_addr_o));
  // R3
  irq_enable_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    irq_o |-> gie_i);
  // R5
  addr_range_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    accept |=> (vec_addr_o >= ADDR_W'(BASE)) &&
               (vec_addr_o <= ADDR_W'(BASE + STRIDE * (NVEC - 1))));
endmodule

// File: tb/test_intc_arbiter.sv
module test_intc_arbiter;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [9:0]  req, sel;
  logic        gie, ack, ret;
  logic        irq;
  logic [15:0] addr;
  logic [1:0]  lvl;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  intc_arbiter i_intc_arbiter (
    .clk(clk), .rst_n(rst_n), .req_i(req), .lvl_sel_i(sel), .gie_i(gie),
    .ack_i(ack), .ret_i(ret), .irq_o(irq), .vec_addr_o(addr), .svc_level_o(lvl)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int vlvl(input int i, input logic [9:0] s);
    if (!s[i]) return 1;
    return (i < 2) ? 3 : 2;
  endfunction

  // returns winner index or -1; level in wl
  function automatic int winner(input logic [9:0] r, input logic [9:0] s,
                                input int floor, output int wl);
    int best = -1;
    wl = 0;
    for (int i = 0; i < 10; i++) begin
      if (r[i] && vlvl(i, s) > floor && vlvl(i, s) > wl) begin
        best = i;
        wl = vlvl(i, s);
      end
    end
    return best;
  endfunction

  task automatic pulse_ack();
    ack = 1'b1; @(negedge clk); ack = 1'b0;
  endtask

  task automatic pulse_ret();
    ret = 1'b1; @(negedge clk); ret = 1'b0;
  endtask

  task automatic sweep(input logic [9:0] s, input int floor);
    for (int r = 0; r < 1024; r++) begin
      int w, wl;
      req = 10'(r); sel = s;
      #1;
      w = winner(10'(r), s, floor, wl);
      chk("R3 irq", int'(irq), (w >= 0) ? 1 : 0);
      @(negedge clk);
      if (w >= 0) begin
        pulse_ack();
        chk("R4 R5 addr", int'(addr), 3 + 8 * w);
        chk("R6 level", int'(lvl), wl);
        pulse_ret();
        chk("R9 level after ret", int'(lvl), floor);
      end
    end
  endtask

  initial begin
    #(20 * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req = '0; sel = '0; gie = 1'b1; ack = 1'b0; ret = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 irq", int'(irq), 0);
    chk("R1 addr", int'(addr), 0);
    chk("R1 level", int'(lvl), 0);

    // R2 R4 exhaustive over request patterns, empty record
    sweep(10'h000, 0);
    sweep(10'h3FF, 0);
    sweep(10'h2A5, 0);
    sweep(10'h15A, 0);

    // low in service, then R8 sweep
    req = 10'b10_0000_0000; sel = '0; #1;
    pulse_ack();
    chk("R6 low in service", int'(lvl), 1);
    chk("R5 addr idx9", int'(addr), 16'h004B);
    sweep(10'h0F3, 1);
    sweep(10'h000, 1);
    pulse_ret();
    chk("R9 back to none", int'(lvl), 0);

    // nesting chain: idx5 low, idx4 high, idx3 high, idx0 top
    sel = 10'b00_0001_1001;
    req = 10'b00_0010_0000; #1;
    chk("R3 irq idx5", int'(irq), 1);
    pulse_ack();
    chk("R5 addr idx5", int'(addr), 16'h002B);
    req = 10'b00_0110_0000; #1;
    chk("R8 low refused", int'(irq), 0);
    req = 10'b00_0111_0000; #1;
    chk("R8 high over low", int'(irq), 1);
    pulse_ack();
    chk("R6 high level", int'(lvl), 2);
    chk("R5 addr idx4", int'(addr), 16'h0023);
    req = 10'b00_0111_1000; #1;
    chk("R8 same high refused", int'(irq), 0);
    req = 10'b00_0111_1001; #1;
    chk("R8 top over high", int'(irq), 1);
    pulse_ack();
    chk("R6 top level", int'(lvl), 3);
    chk("R5 addr idx0", int'(addr), 16'h0003);
    req = 10'h3FF; #1;
    chk("R8 all refused at top", int'(irq), 0);
    req = '0;
    pulse_ret();
    chk("R9 top retired", int'(lvl), 2);
    pulse_ret();
    chk("R9 high retired", int'(lvl), 1);
    pulse_ret();
    chk("R9 low retired", int'(lvl), 0);
    pulse_ret();
    chk("R11 empty ret", int'(lvl), 0);
    chk("R7 addr kept", int'(addr), 16'h0003);

    // R7 ack while gated off
    gie = 1'b0; req = 10'b00_0000_0100; #1;
    chk("R3 gie off", int'(irq), 0);
    pulse_ack();
    chk("R7 ack ignored addr", int'(addr), 16'h0003);
    chk("R7 ack ignored level", int'(lvl), 0);
    gie = 1'b1;

    // R10 same-cycle ack and return
    sel = 10'b00_0000_0010;
    req = 10'b00_0000_0100; #1;   // idx2 low
    pulse_ack();
    chk("R6 idx2 low", int'(lvl), 1);
    chk("R5 addr idx2", int'(addr), 16'h0013);
    req = 10'b00_0000_0010; #1;   // idx1 top
    chk("R3 top pending", int'(irq), 1);
    ack = 1'b1; ret = 1'b1;
    @(negedge clk);
    ack = 1'b0; ret = 1'b0;
    chk("R10 level", int'(lvl), 0);
    chk("R10 addr", int'(addr), 16'h0013);
    req = '0;

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule